// File: doc/BRIEF.md
# Vector Lane Compress Unit

This block takes a vector of byte-wide lanes and a per-lane select mask. It moves every selected lane down toward lane 0 and keeps the selected lanes in their original relative order. It also reports how many lanes were kept. Lanes of the result at or above that count are filled with zeros or with the same-numbered lanes of a pass-through vector, chosen per transfer by a mode pin. A typical use is gathering the interesting bytes of a parsed text chunk so that they sit next to each other in a buffer. Another is listing the positions of matching lanes by compressing a vector of lane indices.

The destination of each selected lane depends on how many unselected lanes lie below it. That number comes from a logarithmic prefix-count network. The lanes then pass through a logarithmic shift network in which each stage moves a lane down by one power of two. The result is captured in a single output register stage.

Data moves on valid/ready handshakes at both ends. An input transfer takes place on a rising clock edge at which `in_valid` and `in_ready` are both high. An output transfer takes place on an edge at which `out_valid` and `out_ready` are both high. `in_ready` is high whenever the output stage is empty or is being emptied in that same cycle, so a full-rate stream needs no bubbles. While `out_valid` is high and `out_ready` is low, the output holds its data and count, and `in_ready` is low. `fill_merge` is sampled together with the input data.

Top module: `lane_compress_top`

## Requirements
- R1: Lane i of a vector occupies bits [i*LANE_W +: LANE_W], and mask bit i selects lane i. The selected lanes appear in output lanes 0, 1, 2, ... in ascending order of their input lane number.
- R2: `out_count` equals the number of set bits in the accepted mask.
- R3: With `fill_merge` = 0, every output lane whose number is at or above `out_count` is zero.
- R4: With `fill_merge` = 1, every output lane whose number is at or above `out_count` equals the same-numbered lane of `in_pass`.
- R5: An all-zero mask gives `out_count` = 0 and an output made only of fill.
- R6: An all-ones mask gives `out_count` = LANES and an output equal to `in_lanes`.
- R7: When lane i holds the value i, the first `out_count` output lanes list the numbers of the set mask bits in ascending order.
- R8: A transfer accepted on one edge is presented with `out_valid` high from that edge on. `in_ready` is high exactly when the output stage is empty or `out_ready` is high.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_lanes` and `out_count` stay unchanged on the next edge.
- R10: While `rst_n` is low, and after it is released until a transfer is accepted, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input vector is offered |
| in_ready | output | 1 | Block can take the input vector |
| in_lanes | input | LANES*LANE_W | Source lanes, lane 0 in the low bits |
| in_mask | input | LANES | Lane select, bit i for lane i |
| in_pass | input | LANES*LANE_W | Pass-through lanes used for merge fill |
| fill_merge | input | 1 | 0 = zero fill, 1 = merge fill from `in_pass` |
| out_valid | output | 1 | Output stage holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_lanes | output | LANES*LANE_W | Packed and filled lanes |
| out_count | output | $clog2(LANES+1) | Number of kept lanes |

## Verification
The two functions that can fall in the same cycle are draining a result from the output stage and accepting a new vector into it. The bench first streams with `in_valid` and `out_ready` held high, so every edge does both. It then repeats the run with both signals driven by pseudo-random patterns, which mixes stalls with drain-and-fill cycles. A queue of results computed in the bench judges every drained result: each one must appear exactly once, in order, and with the right lanes and count. During stalls the held output is compared with its value from the previous cycle. The sweep covers all 256 masks in both fill modes of an 8-lane configuration, plus lane-index vectors.

// File: rtl/lane_compress_pkg.sv
package lane_compress_pkg;

  typedef enum logic {
    FILL_ZERO  = 1'b0,
    FILL_MERGE = 1'b1
  } fill_mode_e;

  // Bits needed to hold a lane count from 0 to n inclusive.
  function automatic int count_width(input int n);
    return $clog2(n + 1);
  endfunction

  // Bits needed to hold a lane shift from 0 to n-1.
  function automatic int shift_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/lc_prefix_count.sv
// Log-depth prefix count of the select mask. For every lane it gives how many
// unselected lanes lie below it, which is how far a selected lane moves down.
module lc_prefix_count #(
  parameter int LANES = 64,
  parameter int CNT_W = 7,
  parameter int SH_W  = 6
) (
  input  logic [LANES-1:0]           mask,
  output logic [LANES-1:0][SH_W-1:0] gap_below,
  output logic [CNT_W-1:0]           kept
);

  localparam int LEVELS = $clog2(LANES);

  logic [CNT_W-1:0] sum [0:LEVELS][0:LANES-1];

  for (genvar i = 0; i < LANES; i++) begin : g_init
    assign sum[0][i] = CNT_W'(mask[i]);
  end

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
    localparam int SPAN = 1 << lv;
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      if (i >= SPAN) begin : g_add
        assign sum[lv+1][i] = sum[lv][i] + sum[lv][i-SPAN];
      end else begin : g_copy
        assign sum[lv+1][i] = sum[lv][i];
      end
    end
  end

  // Unselected lanes below i = i - (selected lanes below i).
  for (genvar i = 0; i < LANES; i++) begin : g_gap
    assign gap_below[i] = SH_W'(i) - SH_W'(sum[LEVELS][i]) + SH_W'(mask[i]);
  end

  assign kept = sum[LEVELS][LANES-1];

endmodule

// File: rtl/lc_shift_net.sv
// Order-preserving compaction: in stage s a lane moves down by 2**s when bit s
// of its shift amount is set. Taking the bits from the least significant one
// upward keeps all moving lanes free of collisions.
module lc_shift_net #(
  parameter int LANES  = 64,
  parameter int LANE_W = 8,
  parameter int SH_W   = 6
) (
  input  logic [LANES-1:0][LANE_W-1:0] lanes_in,
  input  logic [LANES-1:0]             sel,
  input  logic [LANES-1:0][SH_W-1:0]   amt,
  output logic [LANES-1:0][LANE_W-1:0] lanes_out,
  output logic [LANES-1:0]             occupied
);

  logic [LANE_W-1:0] d [0:SH_W][0:LANES-1];
  logic              v [0:SH_W][0:LANES-1];
  logic [SH_W-1:0]   a [0:SH_W-1][0:LANES-1];

  for (genvar j = 0; j < LANES; j++) begin : g_load
    assign d[0][j] = sel[j] ? lanes_in[j] : '0;
    assign v[0][j] = sel[j];
    assign a[0][j] = amt[j];
  end

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int STEP = 1 << s;
    for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic from_up;
      logic stay;
      if (j + STEP < LANES) begin : g_up
        assign from_up = v[s][j+STEP] & a[s][j+STEP][s];
      end else begin : g_top
        assign from_up = 1'b0;
      end
      assign stay = v[s][j] & ~a[s][j][s];

      if (j + STEP < LANES) begin : g_dmux
        assign d[s+1][j] = from_up ? d[s][j+STEP] : (stay ? d[s][j] : '0);
      end else begin : g_dkeep
        assign d[s+1][j] = stay ? d[s][j] : '0;
      end
      assign v[s+1][j] = from_up | stay;

      if (s < SH_W - 1) begin : g_amt
        if (j + STEP < LANES) begin : g_amux
          assign a[s+1][j] = from_up ? a[s][j+STEP] : a[s][j];
        end else begin : g_akeep
          assign a[s+1][j] = a[s][j];
        end
      end
    end
  end

  for (genvar j = 0; j < LANES; j++) begin : g_out
    assign lanes_out[j] = d[SH_W][j];
    assign occupied[j]  = v[SH_W][j];
  end

endmodule

// File: rtl/lc_fill_merge.sv
// Fills every lane that the compaction left empty, with zeros or pass-through.
module lc_fill_merge
  import lane_compress_pkg::*;
#(
  parameter int LANES  = 64,
  parameter int LANE_W = 8
) (
  input  logic [LANES-1:0][LANE_W-1:0] packed_lanes,
  input  logic [LANES-1:0]             occupied,
  input  logic [LANES-1:0][LANE_W-1:0] pass_lanes,
  input  fill_mode_e                   mode,
  output logic [LANES-1:0][LANE_W-1:0] filled
);

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    always_comb begin
      if (occupied[j]) begin
        filled[j] = packed_lanes[j];
      end else if (mode == FILL_MERGE) begin
        filled[j] = pass_lanes[j];
      end else begin
        filled[j] = '0;
      end
    end
  end

endmodule

// File: rtl/lc_out_stage.sv
// One registered stage with valid/ready; refills in the cycle it is drained.
module lc_out_stage #(
  parameter int DATA_W = 512,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [DATA_W-1:0] up_data,
  input  logic [CNT_W-1:0]  up_count,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [DATA_W-1:0] dn_data,
  output logic [CNT_W-1:0]  dn_count
);

  assign up_ready = ~dn_valid | dn_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
      dn_count <= '0;
    end else if (up_ready) begin
      dn_valid <= up_valid;
      if (up_valid) begin
        dn_data  <= up_data;
        dn_count <= up_count;
      end
    end
  end

endmodule

// File: rtl/lane_compress_top.sv
module lane_compress_top
  import lane_compress_pkg::*;
#(
  parameter  int LANES  = 64,
  parameter  int LANE_W = 8,
  localparam int CNT_W  = count_width(LANES),
  localparam int VEC_W  = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VEC_W-1:0] in_lanes,
  input  logic [LANES-1:0] in_mask,
  input  logic [VEC_W-1:0] in_pass,
  input  logic             fill_merge,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_lanes,
  output logic [CNT_W-1:0] out_count
);

  localparam int SH_W = shift_width(LANES);

  logic [LANES-1:0][LANE_W-1:0] src_lanes;
  logic [LANES-1:0][LANE_W-1:0] pass_lanes;
  logic [LANES-1:0][LANE_W-1:0] packed_lanes;
  logic [LANES-1:0][LANE_W-1:0] filled_lanes;
  logic [LANES-1:0][SH_W-1:0]   gap_below;
  logic [LANES-1:0]             occupied;
  logic [CNT_W-1:0]             kept;
  fill_mode_e                   mode;

  assign src_lanes  = in_lanes;
  assign pass_lanes = in_pass;
  assign mode       = fill_mode_e'(fill_merge);

  lc_prefix_count #(
    .LANES (LANES),
    .CNT_W (CNT_W),
    .SH_W  (SH_W)
  ) u_prefix (
    .mask      (in_mask),
    .gap_below (gap_below),
    .kept      (kept)
  );

  lc_shift_net #(
    .LANES  (LANES),
    .LANE_W (LANE_W),
    .SH_W   (SH_W)
  ) u_shift (
    .lanes_in  (src_lanes),
    .sel       (in_mask),
    .amt       (gap_below),
    .lanes_out (packed_lanes),
    .occupied  (occupied)
  );

  lc_fill_merge #(
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) u_fill (
    .packed_lanes (packed_lanes),
    .occupied     (occupied),
    .pass_lanes   (pass_lanes),
    .mode         (mode),
    .filled       (filled_lanes)
  );

  lc_out_stage #(
    .DATA_W (VEC_W),
    .CNT_W  (CNT_W)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (filled_lanes),
    .up_count (kept),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (out_lanes),
    .dn_count (out_count)
  );

endmodule

// File: rtl/lane_compress_chk.sv
module lane_compress_chk #(
  parameter int LANES  = 64,
  parameter int LANE_W = 8,
  parameter int CNT_W  = 7,
  parameter int VEC_W  = 512
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [VEC_W-1:0] in_lanes,
  input logic [LANES-1:0] in_mask,
  input logic [VEC_W-1:0] in_pass,
  input logic             fill_merge,
  input logic             out_valid,
  input logic             out_ready,
  input logic [VEC_W-1:0] out_lanes,
  input logic [CNT_W-1:0] out_count
);

  // R2
  count_matches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_count == CNT_W'($countones($past(in_mask)))));

  // R6
  all_ones_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (&in_mask)) |=> (out_lanes == $past(in_lanes)));

  // R5
  empty_mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mask == '0 && !fill_merge) |=> (out_lanes == '0));

  // R5
  empty_mask_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mask == '0 && fill_merge) |=> (out_lanes == $past(in_pass)));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_lanes) && $stable(out_count)));

  // R8
  empty_takes_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R8
  drain_only_on_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready));

  // R10
  always_comb begin
    if (!rst_n) begin
      reset_idle_chk: assert (!out_valid);
    end
  end

endmodule

bind lane_compress_top lane_compress_chk #(
  .LANES  (LANES),
  .LANE_W (LANE_W),
  .CNT_W  (CNT_W),
  .VEC_W  (VEC_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_lanes   (in_lanes),
  .in_mask    (in_mask),
  .in_pass    (in_pass),
  .fill_merge (fill_merge),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_lanes  (out_lanes),
  .out_count  (out_count)
);

// File: tb/test_lane_compress_top.sv
module test_lane_compress_top;

  localparam int CLK_PERIOD = 10;
  localparam int NL    = 8;
  localparam int LW    = 8;
  localparam int CW    = $clog2(NL + 1);
  localparam int VW    = NL * LW;
  localparam int N_SWEEP = 512;
  localparam int N_IDX   = 16;
  localparam int N_ITEMS = N_SWEEP + N_IDX;
  localparam int MAX_CYCLES = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [VW-1:0] in_lanes = '0;
  logic [NL-1:0] in_mask = '0;
  logic [VW-1:0] in_pass = '0;
  logic          fill_merge = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [VW-1:0] out_lanes;
  logic [CW-1:0] out_count;

  int checks = 0;
  int errors = 0;

  logic [VW-1:0] q_lanes [$];
  int            q_cnt   [$];
  logic [NL-1:0] q_mask  [$];
  logic          q_mode  [$];
  logic          q_idx   [$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  lane_compress_top #(.LANES(NL), .LANE_W(LW)) i_lane_compress_top (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_lanes(in_lanes), .in_mask(in_mask), .in_pass(in_pass),
    .fill_merge(fill_merge),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_lanes(out_lanes), .out_count(out_count)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic void make_item(input int t, output logic [VW-1:0] d,
                                    output logic [NL-1:0] m, output logic [VW-1:0] p,
                                    output logic md, output logic idx);
    idx = (t >= N_SWEEP);
    for (int l = 0; l < NL; l++) begin
      if (idx) d[l*LW +: LW] = LW'(l);
      else     d[l*LW +: LW] = LW'(t * 37 + l * 53 + 11);
      p[l*LW +: LW] = ~LW'(t * 13 + l * 71);
    end
    if (idx) begin
      m  = NL'((t - N_SWEEP) * 29 + 5);
      md = t[0];
    end else begin
      m  = t[7:0];
      md = t[8];
    end
  endfunction

  // Bench model: walk the lanes upward, append each selected one, then fill.
  function automatic void model(input logic [VW-1:0] d, input logic [NL-1:0] m,
                                input logic [VW-1:0] p, input logic md,
                                output logic [VW-1:0] o, output int c);
    c = 0;
    o = '0;
    for (int l = 0; l < NL; l++) begin
      if (m[l]) begin
        o[c*LW +: LW] = d[l*LW +: LW];
        c++;
      end
    end
    for (int j = c; j < NL; j++) o[j*LW +: LW] = md ? p[j*LW +: LW] : '0;
  endfunction

  task automatic judge_output();
    logic [VW-1:0] e;
    logic [VW-1:0] keep_bits;
    int c;
    logic [NL-1:0] m;
    logic md, ix;
    string rp, rf;
    if (q_lanes.size() == 0) begin
      check(1'b0, "R8", "output with nothing accepted", out_lanes, '0);
      return;
    end
    e = q_lanes.pop_front(); c = q_cnt.pop_front(); m = q_mask.pop_front();
    md = q_mode.pop_front(); ix = q_idx.pop_front();
    keep_bits = '0;
    for (int j = 0; j < NL; j++) if (j < c) keep_bits[j*LW +: LW] = '1;
    check(out_count == CW'(c), "R2", "kept count", VW'(out_count), VW'(c));
    rp = (&m) ? "R6" : (ix ? "R7" : "R1");
    check((out_lanes & keep_bits) == (e & keep_bits), rp, "packed lanes",
          out_lanes & keep_bits, e & keep_bits);
    rf = (m == '0) ? "R5" : (md ? "R4" : "R3");
    check((out_lanes & ~keep_bits) == (e & ~keep_bits), rf, "fill lanes",
          out_lanes & ~keep_bits, e & ~keep_bits);
  endtask

  initial begin
    int item;
    int cyc;
    logic [15:0] lfsr;
    bit stalled;
    logic [VW-1:0] held_lanes;
    logic [CW-1:0] held_cnt;
    bit accepted;
    bit random_phase;
    logic [VW-1:0] d, p, e;
    logic [NL-1:0] m;
    logic md, ix;
    int c;

    repeat (3) @(negedge clk);
    // R10: idle during reset
    check(out_valid == 1'b0, "R10", "out_valid in reset", VW'(out_valid), '0);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 and R8: empty after reset, ready to accept
    check(out_valid == 1'b0, "R10", "out_valid after reset", VW'(out_valid), '0);
    check(in_ready == 1'b1, "R8", "in_ready when empty", VW'(in_ready), VW'(1));

    lfsr = 16'hACE1;
    stalled = 1'b0;
    held_lanes = '0;
    held_cnt = '0;
    for (int pass = 0; pass < 2; pass++) begin
      random_phase = (pass == 1);
      item = 0;
      cyc = 0;
      while ((item < N_ITEMS || q_lanes.size() != 0 || out_valid) && cyc < MAX_CYCLES) begin
        cyc++;
        if (stalled) begin
          // R9: output held through a stall
          check(out_valid && out_lanes == held_lanes && out_count == held_cnt, "R9",
                "held output", out_lanes, held_lanes);
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (item < N_ITEMS) begin
          make_item(item, d, m, p, md, ix);
          in_lanes = d; in_mask = m; in_pass = p; fill_merge = md;
          in_valid = random_phase ? (lfsr[3] | lfsr[7]) : 1'b1;
        end else begin
          in_valid = 1'b0;
        end
        out_ready = random_phase ? (lfsr[1] | lfsr[5]) : 1'b1;
        #1;
        // R8: readiness follows the output stage
        check(in_ready == (!out_valid || out_ready), "R8", "in_ready rule",
              VW'(in_ready), VW'(!out_valid || out_ready));
        if (out_valid && out_ready) judge_output();
        accepted = in_valid && in_ready;
        if (accepted) begin
          model(d, m, p, md, e, c);
          q_lanes.push_back(e); q_cnt.push_back(c); q_mask.push_back(m);
          q_mode.push_back(md); q_idx.push_back(ix);
          item++;
        end
        stalled = out_valid && !out_ready;
        held_lanes = out_lanes;
        held_cnt = out_count;
        @(posedge clk);
        @(negedge clk);
        if (accepted) begin
          // R8: accepted transfer is presented after one edge
          check(out_valid == 1'b1, "R8", "out_valid after accept", VW'(out_valid), VW'(1));
        end
      end
      if (cyc >= MAX_CYCLES) begin
        check(1'b0, "R8", "watchdog expired", VW'(cyc), VW'(MAX_CYCLES));
      end
      in_valid = 1'b0;
      out_ready = 1'b0;
      stalled = 1'b0;
      @(negedge clk);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule